// File: doc/BRIEF.md
# Sub-word descriptor load/store unit

This unit carries out the two register-access commands of a descriptor-driven DMA channel: a load, which reads from system memory into the descriptor's command-dependent word, and a store, which writes bytes taken from that word back to memory. The sequencer hands it one command as a single-cycle start pulse. The pulse carries the direction, the key, the byte address, the request count and the current command-dependent word. The unit makes one access on a 32-bit little-endian memory port with per-byte enables. It then returns either a one-cycle completion pulse carrying the updated word or a one-cycle kill pulse.

The access size comes only from the three least significant bits of the request count, and the address is forced into alignment for that size. On a load the fetched bytes go into the most significant end of the word, and the lower bytes of the word are kept. On a store the bytes are taken from the most significant end of the word and steered onto the lanes that the low address bits select. Keys that name the ordinary streams are treated as system memory. A key that still does not name system memory after that remapping kills the command without any memory access.

Top module: `desc_word_mover`

## Requirements
- R1: The size is decoded by priority from count bits 2:0. Bit 2 set gives 4 bytes; otherwise bit 1 set gives 2 bytes; otherwise 1 byte. Count bits above bit 2 have no effect. The number of asserted byte enables equals the size.
- R2: The address is forced into alignment. A 4-byte access clears address bits 1:0, and a 2-byte access clears address bit 0. `mem_addr_o` carries the aligned byte address. Byte enable bit i covers data bits 8i+7:8i, and lanes start at aligned address bits 1:0.
- R3: Key values 0 to 4 are remapped to 6, the system-memory key. After remapping, any key other than 6 (that is, 5 or 7) yields `kill_o` for one cycle, in the cycle after the start, and no memory request.
- R4: A store drives the bytes of the word onto the enabled lanes in little-endian order. A 4-byte store writes the whole word; a 2-byte store writes word bits 31:16; a 1-byte store writes word bits 31:24.
- R5: A 2-byte load returns the fetched halfword in bits 31:16 and keeps bits 15:0 of the word given at start. A 1-byte load returns the fetched byte in bits 31:24 and keeps bits 23:0.
- R6: A 4-byte load replaces the whole word with the read data.
- R7: `mem_req_o` rises in the cycle after an accepted start. It stays high, with address, enables, direction and write data unchanged, until `mem_gnt_i` is sampled high. A store then raises `done_o` in the next cycle, with `dep_o` equal to the word given at start.
- R8: A load completes on the first cycle, from the grant cycle onwards, in which `mem_rvalid_i` is high; this includes the grant cycle itself. `done_o` and the merged `dep_o` follow one cycle later.
- R9: `done_o` and `kill_o` are single-cycle pulses and are never high together.
- R10: A start pulse while `busy_o` is high is ignored. The access in flight keeps its address and direction, and no extra done or kill follows.
- R11: After reset the unit is idle, with `busy_o`, `mem_req_o`, `done_o` and `kill_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle command start |
| store_i | input | 1 | 1 = store command, 0 = load command |
| key_i | input | 3 | Address-space key of the command |
| addr_i | input | AW | Byte address from the descriptor |
| count_i | input | CW | Request count from the descriptor |
| dep_i | input | 32 | Current command-dependent word |
| busy_o | output | 1 | A command is in flight |
| done_o | output | 1 | Completion pulse |
| kill_o | output | 1 | Kill pulse for an unsupported key |
| dep_o | output | 32 | Updated command-dependent word, valid with done_o |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write access |
| mem_addr_o | output | AW | Aligned byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data, lane-steered |
| mem_gnt_i | input | 1 | Memory accepted the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
On a load, the grant and the returning read data can arrive in the same cycle. In that case the unit has to leave the request phase and take the data on the same edge, without entering its wait-for-data state. The sweep covers every size, lane offset and key in both directions. It varies the grant delay, and it varies whether read-valid arrives with the grant or one or two cycles after it. In every variant the merged word and the exact cycle of the done pulse are compared with values the bench computes by shifting and masking.

// File: rtl/dwm_pkg.sv
`timescale 1ns/1ps
package dwm_pkg;

  localparam int unsigned LANES     = 4;
  localparam int unsigned WORD_W    = 8 * LANES;
  localparam logic [2:0]  KEY_SYSMEM = 3'd6;
  localparam logic [2:0]  KEY_STREAM_LIMIT = 3'd5;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2
  } xsize_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCESS = 2'd1,
    PH_RDWAIT = 2'd2
  } phase_e;

  // Priority decode of the three size bits of the request count.
  function automatic xsize_e decode_size(input logic [2:0] cnt);
    if (cnt[2])      return SZ_B4;
    else if (cnt[1]) return SZ_B2;
    return SZ_B1;
  endfunction

  // Low address bits after forcing natural alignment.
  function automatic logic [1:0] force_align(input xsize_e sz, input logic [1:0] lo);
    case (sz)
      SZ_B4:   return 2'b00;
      SZ_B2:   return {lo[1], 1'b0};
      default: return lo;
    endcase
  endfunction

  // Stream keys collapse onto system memory.
  function automatic logic [2:0] remap_key(input logic [2:0] key);
    return (key < KEY_STREAM_LIMIT) ? KEY_SYSMEM : key;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input xsize_e sz, input logic [1:0] lo);
    case (sz)
      SZ_B4:   return 4'b1111;
      SZ_B2:   return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b0001 << lo;
    endcase
  endfunction

  // Fetched bytes enter at the top of the word, lower bytes are kept.
  function automatic logic [WORD_W-1:0] merge_load(input xsize_e sz, input logic [1:0] lo,
                                                   input logic [WORD_W-1:0] rdata,
                                                   input logic [WORD_W-1:0] dep);
    logic [15:0] half;
    logic [7:0]  one;
    half = lo[1] ? rdata[31:16] : rdata[15:0];
    case (lo)
      2'd0:    one = rdata[7:0];
      2'd1:    one = rdata[15:8];
      2'd2:    one = rdata[23:16];
      default: one = rdata[31:24];
    endcase
    case (sz)
      SZ_B4:   return rdata;
      SZ_B2:   return {half, dep[15:0]};
      default: return {one, dep[23:0]};
    endcase
  endfunction

endpackage

// File: rtl/dwm_decode.sv
`timescale 1ns/1ps
module dwm_decode #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0]  count_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [2:0]     key_i,
  output dwm_pkg::xsize_e size_o,
  output logic [AW-1:0]  addr_o,
  output logic           key_ok_o
);
  import dwm_pkg::*;

  logic unused_count_hi;
  assign unused_count_hi = ^count_i[CW-1:3];

  assign size_o   = decode_size(count_i[2:0]);
  assign addr_o   = {addr_i[AW-1:2], force_align(size_o, addr_i[1:0])};
  assign key_ok_o = (remap_key(key_i) == KEY_SYSMEM);

endmodule

// File: rtl/dwm_lanes.sv
`timescale 1ns/1ps
module dwm_lanes (
  input  dwm_pkg::xsize_e size_i,
  input  logic [1:0]      lo_i,
  input  logic [31:0]     dep_i,
  output logic [3:0]      be_o,
  output logic [31:0]     wdata_o
);
  import dwm_pkg::*;

  assign be_o = lane_mask(size_i, lo_i);

  for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
    assign wdata_o[8*i +: 8] = (size_i == SZ_B4) ? dep_i[8*i +: 8] :
                               (size_i == SZ_B2) ? dep_i[16 + 8*(i % 2) +: 8] :
                                                   dep_i[31:24];
  end

endmodule

// File: rtl/dwm_merge.sv
`timescale 1ns/1ps
module dwm_merge (
  input  dwm_pkg::xsize_e size_i,
  input  logic [1:0]      lo_i,
  input  logic [31:0]     rdata_i,
  input  logic [31:0]     dep_i,
  output logic [31:0]     merged_o
);
  import dwm_pkg::*;

  assign merged_o = merge_load(size_i, lo_i, rdata_i, dep_i);

endmodule

// File: rtl/desc_word_mover.sv
`timescale 1ns/1ps
module desc_word_mover #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          store_i,
  input  logic [2:0]    key_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [31:0]   dep_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          kill_o,
  output logic [31:0]   dep_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i
);
  import dwm_pkg::*;

  phase_e        phase_q;
  xsize_e        size_q;
  logic          store_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   dep_q;
  logic          done_q, kill_q;
  logic [31:0]   dep_out_q;

  xsize_e        dec_size;
  logic [AW-1:0] dec_addr;
  logic          dec_key_ok;
  logic [31:0]   merged;

  // Named events for the checker.
  logic ev_accept, ev_grant, ev_store_end, ev_rdata;

  dwm_decode #(.AW(AW), .CW(CW)) u_decode (
    .count_i  (count_i),
    .addr_i   (addr_i),
    .key_i    (key_i),
    .size_o   (dec_size),
    .addr_o   (dec_addr),
    .key_ok_o (dec_key_ok)
  );

  dwm_lanes u_lanes (
    .size_i  (size_q),
    .lo_i    (addr_q[1:0]),
    .dep_i   (dep_q),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  dwm_merge u_merge (
    .size_i   (size_q),
    .lo_i     (addr_q[1:0]),
    .rdata_i  (mem_rdata_i),
    .dep_i    (dep_q),
    .merged_o (merged)
  );

  assign ev_accept    = start_i && (phase_q == PH_IDLE);
  assign ev_grant     = (phase_q == PH_ACCESS) && mem_gnt_i;
  assign ev_store_end = ev_grant && store_q;
  assign ev_rdata     = !store_q && mem_rvalid_i &&
                        (ev_grant || (phase_q == PH_RDWAIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      size_q    <= SZ_B1;
      store_q   <= 1'b0;
      addr_q    <= '0;
      dep_q     <= '0;
      done_q    <= 1'b0;
      kill_q    <= 1'b0;
      dep_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      kill_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (ev_accept) begin
            size_q  <= dec_size;
            store_q <= store_i;
            addr_q  <= dec_addr;
            dep_q   <= dep_i;
            if (dec_key_ok) phase_q <= PH_ACCESS;
            else            kill_q  <= 1'b1;
          end
        end
        PH_ACCESS: begin
          if (ev_store_end) begin
            done_q    <= 1'b1;
            dep_out_q <= dep_q;
            phase_q   <= PH_IDLE;
          end else if (ev_rdata) begin
            done_q    <= 1'b1;
            dep_out_q <= merged;
            phase_q   <= PH_IDLE;
          end else if (ev_grant) begin
            phase_q <= PH_RDWAIT;
          end
        end
        PH_RDWAIT: begin
          if (ev_rdata) begin
            done_q    <= 1'b1;
            dep_out_q <= merged;
            phase_q   <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o     = (phase_q != PH_IDLE);
  assign mem_req_o  = (phase_q == PH_ACCESS);
  assign mem_we_o   = store_q;
  assign mem_addr_o = addr_q;
  assign done_o     = done_q;
  assign kill_o     = kill_q;
  assign dep_o      = dep_out_q;

endmodule

// File: rtl/dwm_checker.sv
`timescale 1ns/1ps
module dwm_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [2:0]    key_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          kill_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [3:0]    mem_be_o,
  input logic          mem_gnt_i,
  input logic          mem_rvalid_i,
  input logic          ev_accept,
  input logic          ev_rdata
);

  assert_be_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                   $countones(mem_be_o) == 4));

  assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_be_o == 4'hF) |-> (mem_addr_o[1:0] == 2'b00));

  assert_half_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && (mem_be_o == 4'h3 || mem_be_o == 4'hC)) |-> !mem_addr_o[0]);

  assert_bad_key_kill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && (key_i == 3'd5 || key_i == 3'd7)) |=> (kill_o && !mem_req_o));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_be_o) && $stable(mem_we_o)));

  assert_store_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_gnt_i) |=> done_o);

  assert_load_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rdata |=> done_o);

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_gnt_i || mem_rvalid_i));

  assert_end_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && kill_o));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_kill_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill_o |=> !kill_o);

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !kill_o);

endmodule

bind desc_word_mover dwm_checker #(.AW(AW)) u_dwm_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .key_i        (key_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .kill_o       (kill_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_be_o     (mem_be_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_rvalid_i (mem_rvalid_i),
  .ev_accept    (ev_accept),
  .ev_rdata     (ev_rdata)
);

// File: tb/tb_desc_word_mover.sv
`timescale 1ns/1ps
module tb_desc_word_mover;
  localparam int unsigned AW = 32;
  localparam int unsigned CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          store_i = 1'b0;
  logic [2:0]    key_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic [31:0]   dep_i = '0;
  logic          busy_o, done_o, kill_o;
  logic [31:0]   dep_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [3:0]    mem_be_o;
  logic [31:0]   mem_wdata_o;
  logic          mem_gnt_i = 1'b0;
  logic          mem_rvalid_i = 1'b0;
  logic [31:0]   mem_rdata_i = '0;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  desc_word_mover #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .store_i(store_i), .key_i(key_i),
    .addr_i(addr_i), .count_i(count_i), .dep_i(dep_i), .busy_o(busy_o),
    .done_o(done_o), .kill_o(kill_o), .dep_o(dep_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
    .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One command through the unit; expected values from the requirements.
  task automatic run_txn(input bit st, input logic [2:0] key, input logic [31:0] addr,
                         input logic [15:0] cnt, input logic [31:0] dep,
                         input logic [31:0] rdata, input int gdly, input int rdly);
    int sz, off;
    longint unsigned alg, fetched, expw, wexp, bmask, keep;
    logic [3:0] be_exp;
    bit is_kill;
    sz = cnt[2] ? 4 : (cnt[1] ? 2 : 1);
    alg = longint'(addr) - (longint'(addr) % sz);
    off = int'(alg % 4);
    be_exp = 4'(((1 << sz) - 1) << off);
    is_kill = (key == 3'd5) || (key == 3'd7);

    @(negedge clk);
    start_i = 1'b1; store_i = st; key_i = key; addr_i = addr; count_i = cnt; dep_i = dep;
    @(negedge clk);
    start_i = 1'b0;
    if (is_kill) begin
      chk(kill_o == 1'b1, "R3 kill pulse", {31'd0, kill_o}, 32'd1);
      chk(mem_req_o == 1'b0, "R3 no request on kill", {31'd0, mem_req_o}, 32'd0);
      chk(done_o == 1'b0, "R9 no done on kill", {31'd0, done_o}, 32'd0);
      @(negedge clk);
      chk(kill_o == 1'b0, "R9 kill single cycle", {31'd0, kill_o}, 32'd0);
      return;
    end
    chk(mem_req_o == 1'b1, "R7 request raised", {31'd0, mem_req_o}, 32'd1);
    chk(mem_we_o == st, "R7 direction", {31'd0, mem_we_o}, {31'd0, st});
    chk(mem_addr_o == 32'(alg), "R2 aligned address", mem_addr_o, 32'(alg));
    chk(mem_be_o == be_exp, "R1 byte enables", {28'd0, mem_be_o}, {28'd0, be_exp});
    if (st) begin
      wexp = ((longint'(dep) >> (32 - 8*sz)) << (8*off));
      bmask = 0;
      for (int b = 0; b < 4; b++) if (be_exp[b]) bmask |= (64'hFF << (8*b));
      chk((longint'(mem_wdata_o) & bmask) == (wexp & bmask), "R4 store lanes",
          mem_wdata_o, 32'(wexp));
    end
    for (int w = 0; w < gdly; w++) begin
      @(negedge clk);
      chk(mem_req_o == 1'b1 && done_o == 1'b0 && mem_addr_o == 32'(alg),
          "R7 hold until grant", {31'd0, mem_req_o}, 32'd1);
    end
    mem_gnt_i = 1'b1;
    if (!st && rdly == 0) begin
      mem_rvalid_i = 1'b1; mem_rdata_i = rdata;
    end
    @(negedge clk);
    mem_gnt_i = 1'b0; mem_rvalid_i = 1'b0;
    if (!st && rdly > 0) begin
      chk(done_o == 1'b0 && mem_req_o == 1'b0, "R8 waits for read data",
          {31'd0, done_o}, 32'd0);
      for (int w = 1; w < rdly; w++) @(negedge clk);
      mem_rvalid_i = 1'b1; mem_rdata_i = rdata;
      @(negedge clk);
      mem_rvalid_i = 1'b0;
    end
    chk(done_o == 1'b1, st ? "R7 store done" : "R8 load done", {31'd0, done_o}, 32'd1);
    if (st) begin
      chk(dep_o == dep, "R7 store returns word", dep_o, dep);
    end else begin
      fetched = (longint'(rdata) >> (8*off)) & ((64'd1 << (8*sz)) - 1);
      keep = (64'd1 << (32 - 8*sz)) - 1;
      expw = (fetched << (32 - 8*sz)) | (longint'(dep) & keep);
      chk(dep_o == 32'(expw), sz == 4 ? "R6 word load" : "R5 sub-word merge",
          dep_o, 32'(expw));
    end
    chk(kill_o == 1'b0, "R9 exclusive", {31'd0, kill_o}, 32'd0);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R9 done single cycle", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && mem_req_o == 0 && done_o == 0 && kill_o == 0, "R11 reset idle",
        {28'd0, busy_o, mem_req_o, done_o, kill_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 0 && mem_req_o == 0, "R11 idle after release",
        {30'd0, busy_o, mem_req_o}, 32'd0);

    // Sweep: direction x key x size bits x lane offset, varied handshake timing.
    for (int st = 0; st < 2; st++)
      for (int k = 0; k < 8; k++)
        for (int c = 0; c < 8; c++)
          for (int a = 0; a < 4; a++) begin
            logic [15:0] cnt;
            logic [31:0] ad;
            cnt = 16'($urandom) & 16'hFFF8 | 16'(c);
            ad  = ($urandom & 32'hFFFF_FFFC) | 32'(a);
            run_txn(st[0], 3'(k), ad, cnt, $urandom, $urandom, (c + a) % 3, (k + a) % 3);
          end

    // R10: start while busy is ignored.
    @(negedge clk);
    start_i = 1'b1; store_i = 1'b1; key_i = 3'd6; addr_i = 32'h0000_0100;
    count_i = 16'd4; dep_i = 32'hCAFE_F00D;
    @(negedge clk);
    start_i = 1'b1; store_i = 1'b0; key_i = 3'd5; addr_i = 32'h0000_0203; count_i = 16'd1;
    @(negedge clk);
    start_i = 1'b0;
    chk(mem_addr_o == 32'h100 && mem_we_o == 1'b1, "R10 in-flight access kept",
        mem_addr_o, 32'h100);
    chk(kill_o == 1'b0, "R10 no kill from ignored start", {31'd0, kill_o}, 32'd0);
    mem_gnt_i = 1'b1;
    @(negedge clk);
    mem_gnt_i = 1'b0;
    chk(done_o == 1'b1 && dep_o == 32'hCAFE_F00D, "R10 original command completes",
        dep_o, 32'hCAFE_F00D);
    @(negedge clk);
    chk(done_o == 1'b0 && kill_o == 1'b0 && busy_o == 1'b0, "R10 nothing extra",
        {29'd0, done_o, kill_o, busy_o}, 32'd0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule